// File: doc/BRIEF.md
# Debug Status and Control Register

This block is the main status and control word of a processor's external debug port. It is one 32-bit register on the debug register bus. It holds a small set of control bits that the debugger can write: halting enable, a two-bit interrupt disable, a trap on debug-register access, memory access mode, trace override and a context-sample select. It also shows status that the core reports: the halt reason, the exception level, the execution width of each level, the security state, a pending-error indication, the channel full, empty, overrun and underrun flags, a sticky cumulative error and a pipeline-advance flag.

The core sends event pulses to the block: debug-state entry, an instruction retired, an exception taken in debug state, and channel overrun and underrun. It also drives level signals that describe its state. Fields live in separate reset domains, and only a cold reset clears them. Power and lock inputs decide whether a bus access is read-write, read-only, or answered with an error. Each access that hits the register gets a response one cycle after the request.

Top module: `dbg_ctlstat_reg`

## Requirements
- R1: The block answers only requests whose address equals byte offset 0x088. It raises rspValid in the cycle after such a request and never for any other address.
- R2: When corePowered=1, doubleLock=0 and osLock=0, an access is read-write if swLock=0 and read-only if swLock=1. Any other combination gives rspErr=1 with rspData=0, and a write in that case changes nothing. A write in read-only mode changes nothing and completes with rspErr=0.
- R3: A write updates only bits 31, 23:22, 21, 20, 19 and 14. Every other bit ignores write data, and reserved bits 17 and 15 always read 0.
- R4: A cold reset clears all control and sticky fields. A warm reset or an external debug reset leaves them unchanged.
- R5: Bit 6 (cumulative error) sets on an exception taken while in debug state and on any transfer or instruction channel overrun or underrun. It stays set until a cold reset.
- R6: Bit 27 (receive overrun) and bit 26 (transmit underrun) are sticky. Bit 28 (instruction overrun) is sticky and clears on debug-state entry.
- R7: Bit 25 (pipeline advance) sets on a retire pulse and clears only on the clear command. When both arrive in the same cycle, the clear wins.
- R8: Debug-state entry forces bit 20 and bit 28 to 0, even over a write or an overrun pulse in the same cycle.
- R9: Bit 16 (secure debug disabled) reads the inverse of secInvDbgEn outside debug state. On entry it captures 0 if the core enters secure, and otherwise the inverse of secInvDbgEn. It holds that value while in debug state.
- R10: Outside debug state, bits 13:10 read 1111 and bits 9:8, 7 and 18 read 0. Inside debug state they show elWidth, curEl, serrPending and nsState.
- R11: Bits 5:0 capture haltCause on entry and hold it while in debug state. Outside debug state they read 000010, or 000001 while restarting=1.
- R12: Bits 30, 29 and 24 show rxFull, txFull and itrEmpty directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Cold reset, active low, clears all fields |
| warmRstN | input | 1 | Warm reset, active low, resets only the bus response |
| extDbgRstN | input | 1 | External debug reset, active low, resets only the bus response |
| busSel | input | 1 | Bus request valid |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| rspValid | output | 1 | Response valid, one cycle after a hit |
| rspErr | output | 1 | Error response |
| rspData | output | 32 | Read data |
| corePowered | input | 1 | Core power domain is up |
| doubleLock | input | 1 | Double lock set |
| osLock | input | 1 | OS lock set |
| swLock | input | 1 | Software lock set |
| dbgEntry | input | 1 | Debug-state entry pulse |
| inDebug | input | 1 | Core is in debug state |
| entrySecure | input | 1 | Core enters debug in secure state |
| secInvDbgEn | input | 1 | Secure invasive debug enabled |
| nsState | input | 1 | Current non-secure state |
| curEl | input | 2 | Current exception level |
| elWidth | input | 4 | Per-level execution width |
| serrPending | input | 1 | Error interrupt pending |
| haltCause | input | 6 | Halt reason code |
| restarting | input | 1 | Core is leaving debug state |
| retirePulse | input | 1 | Instructions retired |
| clrPipeAdv | input | 1 | Clear pipeline-advance command |
| excInDebug | input | 1 | Exception taken in debug state |
| rxFull | input | 1 | Receive channel full |
| txFull | input | 1 | Transmit channel full |
| itrEmpty | input | 1 | Instruction channel empty |
| rxOverrun | input | 1 | Receive overrun pulse |
| txUnderrun | input | 1 | Transmit underrun pulse |
| itrOverrun | input | 1 | Instruction overrun pulse |

## Verification
The write path is tried with eight patterns: all ones, all zeros, single control bits, and mixed words that set both writable and read-only bits. Reading each one back separates the writable set from the ignored and reserved bits. The access mode is tried under each lock and power combination, which separates read-write, read-only and error behaviour. Event pairs that arrive together (a clear with a retire, an entry with a write, an entry with a change of the enable input) separate the priority rules. Two debug entries, one non-secure and one secure, followed by an exit, separate captured values from live ones and from the fixed values shown outside debug state.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;
  localparam int REG_W = 32;
  localparam logic [5:0] ST_NONDEBUG = 6'b000010;
  localparam logic [5:0] ST_RESTART  = 6'b000001;

  typedef enum logic [1:0] {ACC_ERR, ACC_RO, ACC_RW} accMode_e;

  // strobes from bus control to datapath
  typedef struct packed {
    logic hit;
    logic wrEn;
    logic errRsp;
  } busStb_t;
endpackage

// File: rtl/dbgreg_ctrl.sv
module dbgreg_ctrl
  import dbgreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h088
) (
  input  logic              clk,
  input  logic              anyRstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              corePowered,
  input  logic              doubleLock,
  input  logic              osLock,
  input  logic              swLock,
  input  logic [REG_W-1:0]  image,
  output busStb_t           stb,
  output logic              rspValid,
  output logic              rspErr,
  output logic [REG_W-1:0]  rspData
);
  accMode_e mode;
  logic hit;

  always_comb begin
    if (!corePowered || doubleLock || osLock) mode = ACC_ERR;
    else if (swLock)                           mode = ACC_RO;
    else                                       mode = ACC_RW;
  end

  assign hit        = busSel && (busAddr == OFFSET);
  assign stb.hit    = hit;
  assign stb.wrEn   = hit && busWr && (mode == ACC_RW);
  assign stb.errRsp = hit && (mode == ACC_ERR);

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= hit;
      rspErr   <= stb.errRsp;
      rspData  <= (hit && !busWr && (mode != ACC_ERR)) ? image : '0;
    end
  end

  // R1: no response for a missed address
  assert_no_rsp_on_miss_R1: assert property (@(posedge clk) disable iff (!anyRstN)
    (!busSel || busAddr != OFFSET) |=> !rspValid);
  // R2: locked or unpowered access answers with error
  assert_err_when_locked_R2: assert property (@(posedge clk) disable iff (!anyRstN)
    (hit && (!corePowered || doubleLock || osLock)) |=> (rspErr && rspData == '0));
endmodule

// File: rtl/dbgreg_data.sv
module dbgreg_data
  import dbgreg_pkg::*;
(
  input  logic             clk,
  input  logic             coldRstN,
  input  busStb_t          stb,
  input  logic [REG_W-1:0] wdata,
  input  logic             dbgEntry,
  input  logic             inDebug,
  input  logic             entrySecure,
  input  logic             secInvDbgEn,
  input  logic             nsState,
  input  logic [1:0]       curEl,
  input  logic [3:0]       elWidth,
  input  logic             serrPending,
  input  logic [5:0]       haltCause,
  input  logic             restarting,
  input  logic             retirePulse,
  input  logic             clrPipeAdv,
  input  logic             excInDebug,
  input  logic             rxFull,
  input  logic             txFull,
  input  logic             itrEmpty,
  input  logic             rxOverrun,
  input  logic             txUnderrun,
  input  logic             itrOverrun,
  output logic [REG_W-1:0] image
);
  logic       traceOvr, trapAcc, memAcc, smpCtx, haltEn;
  logic [1:0] intDis;
  logic       itrOvr, rxOvr, txUnd, errFlag, pipeAdv, sddHeld;
  logic [5:0] statusHeld;
  logic       anyFault;

  assign anyFault = rxOverrun || txUnderrun || itrOverrun || (excInDebug && inDebug);

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      traceOvr   <= 1'b0;
      intDis     <= 2'b00;
      trapAcc    <= 1'b0;
      memAcc     <= 1'b0;
      smpCtx     <= 1'b0;
      haltEn     <= 1'b0;
      itrOvr     <= 1'b0;
      rxOvr      <= 1'b0;
      txUnd      <= 1'b0;
      errFlag    <= 1'b0;
      pipeAdv    <= 1'b0;
      sddHeld    <= 1'b0;
      statusHeld <= ST_NONDEBUG;
    end else begin
      if (stb.wrEn) begin
        traceOvr <= wdata[31];
        intDis   <= wdata[23:22];
        trapAcc  <= wdata[21];
        memAcc   <= wdata[20];
        smpCtx   <= wdata[19];
        haltEn   <= wdata[14];
      end
      if (dbgEntry) begin
        memAcc     <= 1'b0;
        sddHeld    <= entrySecure ? 1'b0 : ~secInvDbgEn;
        statusHeld <= haltCause;
      end
      if (dbgEntry)        itrOvr <= 1'b0;
      else if (itrOverrun) itrOvr <= 1'b1;
      if (rxOverrun)  rxOvr   <= 1'b1;
      if (txUnderrun) txUnd   <= 1'b1;
      if (anyFault)   errFlag <= 1'b1;
      if (clrPipeAdv)       pipeAdv <= 1'b0;
      else if (retirePulse) pipeAdv <= 1'b1;
    end
  end

  always_comb begin
    image        = '0;
    image[31]    = traceOvr;
    image[30]    = rxFull;
    image[29]    = txFull;
    image[28]    = itrOvr;
    image[27]    = rxOvr;
    image[26]    = txUnd;
    image[25]    = pipeAdv;
    image[24]    = itrEmpty;
    image[23:22] = intDis;
    image[21]    = trapAcc;
    image[20]    = memAcc;
    image[19]    = smpCtx;
    image[18]    = inDebug ? nsState : 1'b0;
    image[16]    = inDebug ? sddHeld : ~secInvDbgEn;
    image[14]    = haltEn;
    image[13:10] = inDebug ? elWidth : 4'hF;
    image[9:8]   = inDebug ? curEl : 2'b00;
    image[7]     = inDebug ? serrPending : 1'b0;
    image[6]     = errFlag;
    image[5:0]   = inDebug ? statusHeld : (restarting ? ST_RESTART : ST_NONDEBUG);
  end

  // R5: cumulative error never clears without cold reset
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!coldRstN)
    errFlag |=> errFlag);
  // R7: clear command beats retire
  assert_pipe_clear_wins_R7: assert property (@(posedge clk) disable iff (!coldRstN)
    clrPipeAdv |=> !pipeAdv);
  // R8: entry forces memory access mode and instruction overrun low
  assert_entry_clears_R8: assert property (@(posedge clk) disable iff (!coldRstN)
    dbgEntry |=> (!memAcc && !itrOvr));
  // R3: control bits move only on an accepted write
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!coldRstN)
    (!stb.wrEn && !dbgEntry) |=> $stable({traceOvr, intDis, trapAcc, memAcc, smpCtx, haltEn}));
  // R6: receive overrun stays set
  assert_rxovr_sticky_R6: assert property (@(posedge clk) disable iff (!coldRstN)
    rxOvr |=> rxOvr);
endmodule

// File: rtl/dbg_ctlstat_reg.sv
module dbg_ctlstat_reg
  import dbgreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h088
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              warmRstN,
  input  logic              extDbgRstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [31:0]       rspData,
  input  logic              corePowered,
  input  logic              doubleLock,
  input  logic              osLock,
  input  logic              swLock,
  input  logic              dbgEntry,
  input  logic              inDebug,
  input  logic              entrySecure,
  input  logic              secInvDbgEn,
  input  logic              nsState,
  input  logic [1:0]        curEl,
  input  logic [3:0]        elWidth,
  input  logic              serrPending,
  input  logic [5:0]        haltCause,
  input  logic              restarting,
  input  logic              retirePulse,
  input  logic              clrPipeAdv,
  input  logic              excInDebug,
  input  logic              rxFull,
  input  logic              txFull,
  input  logic              itrEmpty,
  input  logic              rxOverrun,
  input  logic              txUnderrun,
  input  logic              itrOverrun
);
  busStb_t stb;
  logic [REG_W-1:0] image;
  logic anyRstN;

  assign anyRstN = coldRstN & warmRstN & extDbgRstN;

  dbgreg_ctrl #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_ctrl (
    .clk(clk), .anyRstN(anyRstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .corePowered(corePowered), .doubleLock(doubleLock), .osLock(osLock), .swLock(swLock),
    .image(image), .stb(stb), .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData)
  );

  dbgreg_data u_data (
    .clk(clk), .coldRstN(coldRstN), .stb(stb), .wdata(busWdata),
    .dbgEntry(dbgEntry), .inDebug(inDebug), .entrySecure(entrySecure),
    .secInvDbgEn(secInvDbgEn), .nsState(nsState), .curEl(curEl), .elWidth(elWidth),
    .serrPending(serrPending), .haltCause(haltCause), .restarting(restarting),
    .retirePulse(retirePulse), .clrPipeAdv(clrPipeAdv), .excInDebug(excInDebug),
    .rxFull(rxFull), .txFull(txFull), .itrEmpty(itrEmpty),
    .rxOverrun(rxOverrun), .txUnderrun(txUnderrun), .itrOverrun(itrOverrun),
    .image(image)
  );
endmodule

// File: tb/dbg_ctlstat_reg_bench.sv
module dbg_ctlstat_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] REG_ADDR = 12'h088;
  localparam int NVEC = 8;
  // write data, expected writable-bit image
  localparam logic [63:0] VEC [NVEC] = '{
    {32'hFFFFFFFF, 32'h80F84000}, {32'h00000000, 32'h00000000},
    {32'h80000000, 32'h80000000}, {32'h00400000, 32'h00400000},
    {32'h00804000, 32'h00804000}, {32'h12345678, 32'h00304000},
    {32'hA5A5A5A5, 32'h80A00000}, {32'h7F07BFFF, 32'h00000000}
  };

  logic clk = 0, coldRstN = 0, warmRstN = 1, extDbgRstN = 1;
  logic busSel = 0, busWr = 0;
  logic [11:0] busAddr = 0;
  logic [31:0] busWdata = 0;
  logic rspValid, rspErr;
  logic [31:0] rspData;
  logic corePowered = 1, doubleLock = 0, osLock = 0, swLock = 0;
  logic dbgEntry = 0, inDebug = 0, entrySecure = 0, secInvDbgEn = 1, nsState = 0;
  logic [1:0] curEl = 0;
  logic [3:0] elWidth = 0;
  logic serrPending = 0, restarting = 0, retirePulse = 0, clrPipeAdv = 0, excInDebug = 0;
  logic [5:0] haltCause = 0;
  logic rxFull = 0, txFull = 0, itrEmpty = 0, rxOverrun = 0, txUnderrun = 0, itrOverrun = 0;
  int nChecks = 0, nFails = 0;
  logic [31:0] rd;
  logic re, rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_ctlstat_reg u_dbg_ctlstat_reg (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d, output logic e, output logic v);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = a;
    @(negedge clk); busSel = 0;
    d = rspData; e = rspErr; v = rspValid;
  endtask

  task automatic busWrite(input logic [31:0] w, output logic e);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = REG_ADDR; busWdata = w;
    @(negedge clk); busSel = 0; busWr = 0;
    e = rspErr;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic coldReset();
    @(negedge clk); coldRstN = 0;
    @(negedge clk); coldRstN = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    coldRstN = 1;
    // R4 reset image, R1 response on hit
    busRead(REG_ADDR, rd, re, rv);
    check("R4 cold reset image", rd, 32'h00003C02);
    check("R1 valid on hit", {31'b0, rv}, 32'h1);

    // R3 write mask table
    for (int i = 0; i < NVEC; i++) begin
      busWrite(VEC[i][63:32], re);
      busRead(REG_ADDR, rd, re, rv);
      check("R3 writable bits", rd, VEC[i][31:0] | 32'h00003C02);
    end

    // R4 warm and external debug resets keep fields
    busWrite(32'h80004000, re);
    @(negedge clk); warmRstN = 0; @(negedge clk); warmRstN = 1;
    busRead(REG_ADDR, rd, re, rv);
    check("R4 warm reset keeps", rd, 32'h80007C02);
    @(negedge clk); extDbgRstN = 0; @(negedge clk); extDbgRstN = 1;
    busRead(REG_ADDR, rd, re, rv);
    check("R4 ext reset keeps", rd, 32'h80007C02);

    // R2 read-only mode
    swLock = 1;
    busWrite(32'h00000000, re);
    check("R2 RO write no error", {31'b0, re}, 32'h0);
    busRead(REG_ADDR, rd, re, rv);
    check("R2 RO write ignored", rd, 32'h80007C02);
    swLock = 0;

    // R2 error mode
    osLock = 1;
    busRead(REG_ADDR, rd, re, rv);
    check("R2 oslock error", {31'b0, re}, 32'h1);
    check("R2 error data zero", rd, 32'h0);
    busWrite(32'h00000000, re);
    osLock = 0;
    busRead(REG_ADDR, rd, re, rv);
    check("R2 locked write ignored", rd, 32'h80007C02);
    doubleLock = 1;
    busRead(REG_ADDR, rd, re, rv);
    check("R2 double lock error", {31'b0, re}, 32'h1);
    doubleLock = 0; corePowered = 0;
    busRead(REG_ADDR, rd, re, rv);
    check("R2 unpowered error", {31'b0, re}, 32'h1);
    corePowered = 1;

    // R1 other address
    busRead(12'h08C, rd, re, rv);
    check("R1 no response off address", {31'b0, rv}, 32'h0);

    // R7 pipeline advance
    pulse(retirePulse);
    busRead(REG_ADDR, rd, re, rv);
    check("R7 retire sets", rd, 32'h82007C02);
    @(negedge clk); retirePulse = 1; clrPipeAdv = 1;
    @(negedge clk); retirePulse = 0; clrPipeAdv = 0;
    busRead(REG_ADDR, rd, re, rv);
    check("R7 clear wins", rd, 32'h80007C02);
    pulse(retirePulse);
    pulse(clrPipeAdv);
    busRead(REG_ADDR, rd, re, rv);
    check("R7 clear after retire", rd, 32'h80007C02);

    // R5 R6 sticky flags
    pulse(rxOverrun);
    repeat (3) @(negedge clk);
    busRead(REG_ADDR, rd, re, rv);
    check("R6 R5 rx overrun sticky", rd, 32'h88007C42);
    pulse(txUnderrun);
    busRead(REG_ADDR, rd, re, rv);
    check("R6 tx underrun", rd, 32'h8C007C42);

    // R12 direct channel status
    rxFull = 1; txFull = 1; itrEmpty = 1;
    busRead(REG_ADDR, rd, re, rv);
    check("R12 channel status", rd, 32'hED007C42);
    rxFull = 0; txFull = 0; itrEmpty = 0;

    // R6 R8 R9 R10 R11 non-secure entry
    busWrite(32'h80104000, re);
    pulse(itrOverrun);
    secInvDbgEn = 0;
    busRead(REG_ADDR, rd, re, rv);
    check("R9 live inverse outside debug", rd, 32'h9C117C42);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = REG_ADDR; busWdata = 32'h80104000;
    dbgEntry = 1; haltCause = 6'b000111; entrySecure = 0;
    @(negedge clk);
    busSel = 0; busWr = 0; dbgEntry = 0; inDebug = 1;
    curEl = 2'b10; elWidth = 4'b1100; nsState = 1; serrPending = 1;
    secInvDbgEn = 1; haltCause = 6'b101011;
    busRead(REG_ADDR, rd, re, rv);
    check("R8 R9 R10 R11 debug image", rd, 32'h8C0572C7);

    // R10 R11 exit
    @(negedge clk); inDebug = 0; restarting = 1;
    busRead(REG_ADDR, rd, re, rv);
    check("R11 R10 restarting image", rd, 32'h8C007C41);
    restarting = 0;
    busRead(REG_ADDR, rd, re, rv);
    check("R11 non-debug status", rd, 32'h8C007C42);

    // R4 cold reset clears, R9 secure entry, R5 exception in debug
    coldReset();
    secInvDbgEn = 0;
    busRead(REG_ADDR, rd, re, rv);
    check("R4 cold clears", rd, 32'h00013C02);
    @(negedge clk); dbgEntry = 1; entrySecure = 1; haltCause = 6'b010011;
    @(negedge clk); dbgEntry = 0; inDebug = 1; curEl = 2'b11; elWidth = 4'hF;
    nsState = 0; serrPending = 0;
    pulse(excInDebug);
    busRead(REG_ADDR, rd, re, rv);
    check("R9 R5 R11 secure entry", rd, 32'h00003F53);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule